// File: doc/BRIEF.md
# Serial Latch-Addressed Configuration Port

This block is a three-wire configuration port: a serial clock, a serial data line and a latch enable. A host shifts a 24-bit word into the port, most significant bit first. It then raises latch enable to commit that word. The two lowest bits of each word name the destination. Because every word carries its own address, the host can update the four configuration registers in any order, one word per latch pulse.

The three serial pins are asynchronous to the system clock. Each pin passes through a flop synchronizer, and its edges are detected in the system clock domain. Each held register keeps the 22 upper bits of the word that addressed it. The port also presents decoded counter fields for the divider logic around it. A word written to the initialization register is copied into the function register as well, and the port raises a single-cycle strobe so that downstream logic can restart.

Top module: `serial_cfg_port`

## Requirements
- R1: While reset is asserted, and after it is released, all four held registers read zero and init_stb_o is low.
- R2: ser_data_i is sampled on each synchronized rising edge of ser_clk_i, and bits enter at the LSB so that the first bit sent lands in bit 23. Each held word output is bits 23..2 of the committed word.
- R3: Clock edges on ser_clk_i without a rising edge of ser_le_i leave all four held registers unchanged.
- R4: On a rising edge of ser_le_i, word bits 1..0 = 00 load ref_word_o, and the other three registers keep their values.
- R5: Address 01 loads div_word_o, and the other three registers keep their values.
- R6: Address 10 loads func_word_o, and the other three registers keep their values.
- R7: Address 11 loads both init_word_o and func_word_o with the same body, leaves ref_word_o and div_word_o unchanged, and pulses init_stb_o high for exactly one clock.
- R8: ref_count_o is word bits 15..2 of the reference register (14 bits). div_a_o is word bits 7..2 of the divider register (6 bits). div_b_o is word bits 20..8 of the divider register (13 bits).
- R9: With two synchronizer stages, a register changes on the third rising clk_i edge after ser_le_i goes high, and not before.
- R10: When more than 24 bits are shifted before a commit, only the last 24 are used.
- R11: Holding ser_le_i high commits once. Bits shifted while it stays high are committed only on its next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_clk_i | input | 1 | Serial shift clock, asynchronous |
| ser_data_i | input | 1 | Serial data, MSB first |
| ser_le_i | input | 1 | Latch enable; its rising edge commits the word |
| ref_word_o | output | 22 | Held reference counter word, bits 23..2 |
| div_word_o | output | 22 | Held divider word, bits 23..2 |
| func_word_o | output | 22 | Held function word, bits 23..2 |
| init_word_o | output | 22 | Held initialization word, bits 23..2 |
| ref_count_o | output | 14 | Reference count field |
| div_a_o | output | 6 | Divider A field |
| div_b_o | output | 13 | Divider B field |
| init_stb_o | output | 1 | One-cycle pulse after an initialization write |

## Verification
The hardest case to reach is latch enable staying high while the serial clock keeps shifting. In that case the commit must come only from the next latch rising edge. The stimulus commits a function word and keeps latch enable high while it shifts a complete divider word. It confirms that the divider register has not moved, and then drops and raises latch enable again. Overlong frames and serial activity with no latch pulse are also driven. The sampling cycle around a latch edge is checked directly against the synchronizer depth.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned N_REGS = 1 << ADDR_W;

  typedef enum logic [ADDR_W-1:0] {
    SEL_REF  = 2'b00,
    SEL_DIV  = 2'b01,
    SEL_FUNC = 2'b10,
    SEL_INIT = 2'b11
  } sel_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] pipe_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
      last_q <= 1'b0;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], pin_i};
      last_q <= pipe_q[STAGES-1];
    end
  end

  assign level_o = pipe_q[STAGES-1];
  assign rise_o  = pipe_q[STAGES-1] & ~last_q;

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R9
endmodule

// File: rtl/shift_word.sv
module shift_word #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_o <= '0;
    else if (shift_i) word_o <= {word_o[WORD_W-2:0], bit_i};
  end

  AST_SHIFT_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> word_o[0] == $past(bit_i)); // R2
  AST_SHIFT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(word_o)); // R2
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_port_pkg::*;
#(
  parameter int unsigned WORD_W = 24,
  localparam int unsigned BODY_W = WORD_W - ADDR_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           commit_i,
  input  logic [WORD_W-1:0]              word_i,
  output logic [N_REGS-1:0][BODY_W-1:0]  regs_o,
  output logic                           init_stb_o
);
  logic [ADDR_W-1:0] sel;
  logic [BODY_W-1:0] body;
  logic [N_REGS-1:0] wr_en;

  assign sel  = word_i[ADDR_W-1:0];
  assign body = word_i[WORD_W-1:ADDR_W];

  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    // the function register also takes initialization writes
    if (g == int'(SEL_FUNC)) begin : g_func
      assign wr_en[g] = commit_i && (sel == SEL_FUNC || sel == SEL_INIT);
    end else begin : g_plain
      assign wr_en[g] = commit_i && (sel == ADDR_W'(g));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       regs_o[g] <= '0;
      else if (wr_en[g]) regs_o[g] <= body;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) init_stb_o <= 1'b0;
    else         init_stb_o <= commit_i && (sel == SEL_INIT);
  end

  AST_WR_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && sel == SEL_DIV |=> regs_o[SEL_DIV] == $past(body)); // R5
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import cfg_port_pkg::*;
#(
  parameter int unsigned WORD_W      = 24,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned REF_CNT_W   = 14,
  parameter int unsigned REF_CNT_LSB = 2,
  parameter int unsigned DIV_A_W     = 6,
  parameter int unsigned DIV_A_LSB   = 2,
  parameter int unsigned DIV_B_W     = 13,
  parameter int unsigned DIV_B_LSB   = 8,
  localparam int unsigned BODY_W     = WORD_W - ADDR_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ser_clk_i,
  input  logic                 ser_data_i,
  input  logic                 ser_le_i,
  output logic [BODY_W-1:0]    ref_word_o,
  output logic [BODY_W-1:0]    div_word_o,
  output logic [BODY_W-1:0]    func_word_o,
  output logic [BODY_W-1:0]    init_word_o,
  output logic [REF_CNT_W-1:0] ref_count_o,
  output logic [DIV_A_W-1:0]   div_a_o,
  output logic [DIV_B_W-1:0]   div_b_o,
  output logic                 init_stb_o
);
  localparam int unsigned N_PINS = 3;
  localparam int unsigned P_CLK  = 0;
  localparam int unsigned P_DAT  = 1;
  localparam int unsigned P_LE   = 2;

  logic [N_PINS-1:0] pin_raw, pin_lvl, pin_rise;
  logic [WORD_W-1:0] shift_q;
  logic [N_REGS-1:0][BODY_W-1:0] regs;

  assign pin_raw = {ser_le_i, ser_data_i, ser_clk_i};

  for (genvar p = 0; p < N_PINS; p++) begin : g_sync
    pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pin_raw[p]),
      .level_o(pin_lvl[p]),
      .rise_o (pin_rise[p])
    );
  end

  shift_word #(.WORD_W(WORD_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(pin_rise[P_CLK]),
    .bit_i  (pin_lvl[P_DAT]),
    .word_o (shift_q)
  );

  cfg_reg_bank #(.WORD_W(WORD_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .commit_i  (pin_rise[P_LE]),
    .word_i    (shift_q),
    .regs_o    (regs),
    .init_stb_o(init_stb_o)
  );

  assign ref_word_o  = regs[SEL_REF];
  assign div_word_o  = regs[SEL_DIV];
  assign func_word_o = regs[SEL_FUNC];
  assign init_word_o = regs[SEL_INIT];

  assign ref_count_o = ref_word_o[REF_CNT_LSB-ADDR_W +: REF_CNT_W];
  assign div_a_o     = div_word_o[DIV_A_LSB-ADDR_W +: DIV_A_W];
  assign div_b_o     = div_word_o[DIV_B_LSB-ADDR_W +: DIV_B_W];

  AST_NO_COMMIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_rise[P_LE] |=> $stable(ref_word_o) && $stable(div_word_o)
                        && $stable(func_word_o) && $stable(init_word_o)); // R3
  AST_REF_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_rise[P_LE] && shift_q[ADDR_W-1:0] == SEL_REF |=>
      $stable(div_word_o) && $stable(func_word_o) && $stable(init_word_o)); // R4
  AST_INIT_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_stb_o |-> func_word_o == init_word_o); // R7
  AST_STB_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_stb_o |=> !init_stb_o); // R7
endmodule

// File: tb/sim_serial_cfg_port.sv
`timescale 1ns/1ps
module sim_serial_cfg_port;
  localparam int HOLD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdat = 1'b0, sle = 1'b0;
  logic [21:0] ref_w, div_w, func_w, init_w;
  logic [13:0] ref_cnt;
  logic [5:0]  div_a;
  logic [12:0] div_b;
  logic        stb;

  int checks = 0;
  int errors = 0;
  int stb_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  serial_cfg_port u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ser_clk_i(sclk), .ser_data_i(sdat), .ser_le_i(sle),
    .ref_word_o(ref_w), .div_word_o(div_w), .func_word_o(func_w),
    .init_word_o(init_w), .ref_count_o(ref_cnt), .div_a_o(div_a),
    .div_b_o(div_b), .init_stb_o(stb)
  );

  // reference model: pin history per system clock, word and registers
  bit qc[4], qd[4], ql[4];
  logic [23:0] m_sh;
  logic [21:0] m_ref, m_div, m_func, m_init;
  logic        m_stb;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin qc[i] = 0; qd[i] = 0; ql[i] = 0; end
      m_sh = '0; m_ref = '0; m_div = '0; m_func = '0; m_init = '0; m_stb = 0;
    end else begin
      for (int i = 3; i > 0; i--) begin qc[i] = qc[i-1]; qd[i] = qd[i-1]; ql[i] = ql[i-1]; end
      qc[0] = sclk; qd[0] = sdat; ql[0] = sle;
      m_stb = 0;
      if (ql[2] && !ql[3]) begin
        case (m_sh[1:0])
          2'b00: m_ref = m_sh[23:2];
          2'b01: m_div = m_sh[23:2];
          2'b10: m_func = m_sh[23:2];
          default: begin m_init = m_sh[23:2]; m_func = m_sh[23:2]; m_stb = 1; end
        endcase
      end
      if (qc[2] && !qc[3]) m_sh = {m_sh[22:0], qd[2]};
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(ref_w == m_ref, "R4 ref", 32'(ref_w), 32'(m_ref));
      chk(div_w == m_div, "R5 div", 32'(div_w), 32'(m_div));
      chk(func_w == m_func, "R6 func", 32'(func_w), 32'(m_func));
      chk(init_w == m_init, "R7 init", 32'(init_w), 32'(m_init));
      chk(stb == m_stb, "R7 strobe", 32'(stb), 32'(m_stb));
      chk(ref_cnt == m_ref[13:0], "R8 ref count", 32'(ref_cnt), 32'(m_ref[13:0]));
      chk(div_a == m_div[5:0], "R8 div a", 32'(div_a), 32'(m_div[5:0]));
      chk(div_b == m_div[18:6], "R8 div b", 32'(div_b), 32'(m_div[18:6]));
      if (stb) stb_cnt++;
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = v[i];
      wait_n(HOLD);
      sclk = 1'b1;
      wait_n(HOLD);
      sclk = 1'b0;
    end
    wait_n(HOLD);
  endtask

  task automatic pulse_le();
    sle = 1'b1;
    wait_n(5);
    sle = 1'b0;
    wait_n(5);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic logic [23:0] mk(input logic [21:0] body, input logic [1:0] sel);
    return {body, sel};
  endfunction

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [21:0] lfsr;
    int s0;
    wait_n(3);
    chk(ref_w == 0 && div_w == 0 && func_w == 0 && init_w == 0 && !stb, "R1 in reset",
        32'(ref_w | div_w | func_w | init_w), 0);
    rst_n = 1'b1;
    wait_n(2);
    chk(ref_w == 0 && div_w == 0 && func_w == 0 && init_w == 0 && !stb, "R1 after reset",
        32'(ref_w | div_w | func_w | init_w), 0);

    // R2: MSB-first placement
    send_bits(32'(mk(22'h2A5C3F, 2'b00)), 24);
    pulse_le();
    chk(ref_w == 22'h2A5C3F, "R2 msb first", 32'(ref_w), 32'h2A5C3F);
    chk(ref_cnt == 14'h1C3F, "R8 ref count field", 32'(ref_cnt), 32'h1C3F);

    send_bits(32'(mk(22'h13579B, 2'b01)), 24);
    pulse_le();
    chk(div_w == 22'h13579B, "R5 div write", 32'(div_w), 32'h13579B);
    chk(div_a == 6'h1B && div_b == 13'h0D5E, "R8 div fields",
        32'({div_b, div_a}), 32'({13'h0D5E, 6'h1B}));

    send_bits(32'(mk(22'h0F0F0F, 2'b10)), 24);
    pulse_le();
    chk(func_w == 22'h0F0F0F && init_w == 0, "R6 func write", 32'(func_w), 32'h0F0F0F);

    s0 = stb_cnt;
    send_bits(32'(mk(22'h3C3C3C, 2'b11)), 24);
    pulse_le();
    chk(init_w == 22'h3C3C3C && func_w == 22'h3C3C3C, "R7 init mirrors func",
        32'(func_w), 32'h3C3C3C);
    chk(stb_cnt - s0 == 1, "R7 single strobe", 32'(stb_cnt - s0), 1);
    chk(ref_w == 22'h2A5C3F && div_w == 22'h13579B, "R7 others kept", 32'(ref_w), 32'h2A5C3F);

    // R3: shifting without latch enable
    send_bits(32'(mk(22'h111111, 2'b00)), 24);
    wait_n(10);
    chk(ref_w == 22'h2A5C3F, "R3 no commit", 32'(ref_w), 32'h2A5C3F);

    // R9: latency through synchronizer
    sle = 1'b1;
    wait_n(2);
    chk(ref_w == 22'h2A5C3F, "R9 not yet", 32'(ref_w), 32'h2A5C3F);
    wait_n(1);
    chk(ref_w == 22'h111111, "R9 third edge", 32'(ref_w), 32'h111111);
    sle = 1'b0;
    wait_n(5);

    // R10: overlong frame keeps the last 24 bits
    send_bits(32'h3F000000 | 32'(mk(22'h2BCDE1, 2'b01)), 30);
    pulse_le();
    chk(div_w == 22'h2BCDE1, "R10 last 24 bits", 32'(div_w), 32'h2BCDE1);

    // R11: latch held high while shifting
    send_bits(32'(mk(22'h0AAAAA, 2'b10)), 24);
    sle = 1'b1;
    wait_n(5);
    send_bits(32'(mk(22'h155555, 2'b01)), 24);
    wait_n(5);
    chk(div_w == 22'h2BCDE1, "R11 no commit while high", 32'(div_w), 32'h2BCDE1);
    chk(func_w == 22'h0AAAAA, "R11 first commit", 32'(func_w), 32'h0AAAAA);
    sle = 1'b0;
    wait_n(5);
    pulse_le();
    chk(div_w == 22'h155555, "R11 next rise commits", 32'(div_w), 32'h155555);

    // pseudo-random words across all addresses
    lfsr = 22'h1ACE5;
    for (int k = 0; k < 12; k++) begin
      lfsr = {lfsr[20:0], lfsr[21] ^ lfsr[20]};
      send_bits(32'(mk(lfsr, 2'(k))), 24);
      pulse_le();
    end
    chk(m_ref == ref_w, "R4 after random sweep", 32'(ref_w), 32'(m_ref));

    wait_n(5);
    finish_run();
  end
endmodule